// File: doc/BRIEF.md
# Three-Master Shared Bus Arbiter with Parking

This block decides which of three requesters owns one shared bus: a processor core, a DMA engine, or an outside master. The outside master is gated by an active-low grant input (`ext_gnt_n`). When that input is high (negated), the outside master comes first and the core second. When it is low, the core and the DMA share the bus under a 2-bit parking policy. Ownership is re-decided only at bus-cycle boundaries, marked by `cycle_done`. Out of reset, and while nobody asks for the bus, the bus stays with a parked master.

After every outside tenure, the core wins the first decision if it is requesting. The programmed policy applies again from the decision after that. A control bit, `ext_access_en`, lets the outside master reach internal resources. While it is set and `ext_gnt_n` is high, the core and the DMA are kept off the bus. The same bit also turns the transfer-acknowledge pin into an output during internal register transfers, and a second bit, `show_data_en`, additionally drives the internal transfer data out for visibility.

Top module: `bus_arbiter3`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `gnt_core` is 1 and `gnt_dma` and `gnt_ext` are 0.
- R2: The grant outputs change only after a clock edge at which `cycle_done` is 1. Otherwise all three grant outputs hold their values.
- R3: At most one of `gnt_core`, `gnt_dma` and `gnt_ext` is 1 in any cycle.
- R4: A decision made with `ext_gnt_n`=1 and `ext_req`=1 grants the outside master. A decision made with `ext_gnt_n`=0 never grants it.
- R5: A decision made with `ext_gnt_n`=1 and `ext_access_en`=1 grants neither the core nor the DMA. If `ext_req` is 0, no grant is active at all.
- R6: The core wins a decision whenever `core_req`=1, R4 and R5 do not apply, and either `ext_gnt_n`=1 or the bus is currently held by the outside master or by nobody.
- R7: Core priority after an outside tenure lasts for exactly one decision. The next decision made with `ext_gnt_n`=0 follows the park policy, so under `park_mode`=2'b10 with both requesting, the DMA wins.
- R8: With `park_mode`=2'b11, the internal holder keeps the bus while its request is 1. The bus passes to the other internal master only when the holder's request is 0 and the other's request is 1.
- R9: With `park_mode`=2'b01, the DMA wins only if `dma_req`=1 and `core_req`=0; otherwise the core is granted. With `park_mode`=2'b10, the core wins only if `core_req`=1 and `dma_req`=0; otherwise the DMA is granted.
- R10: With `park_mode`=2'b00, a single requester wins. Two requesters alternate, with the one that did not hold the bus last going first. With no requester, the last internal holder keeps the bus.
- R11: `ta_oe` is 1 exactly when `ext_access_en`=1, `int_reg_xfer`=1 and the core or the DMA is granted.
- R12: `show_data_oe` is 1 exactly when `ta_oe` is 1 and `show_data_en` is 1. With `ext_access_en`=0, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| core_req | input | 1 | Core bus request |
| dma_req | input | 1 | DMA bus request |
| ext_req | input | 1 | Outside master bus request |
| ext_gnt_n | input | 1 | Active-low grant input; 1 gives the outside master priority |
| park_mode | input | 2 | 00 round-robin, 01 park core, 10 park DMA, 11 park on current holder |
| cycle_done | input | 1 | Bus-cycle boundary; ownership is re-decided at this edge |
| ext_access_en | input | 1 | Outside master may reach internal resources |
| show_data_en | input | 1 | Drive internal register transfer data externally |
| int_reg_xfer | input | 1 | Current transfer targets an internal register |
| gnt_core | output | 1 | Core owns the bus |
| gnt_dma | output | 1 | DMA owns the bus |
| gnt_ext | output | 1 | Outside master owns the bus |
| ta_oe | output | 1 | Transfer-acknowledge driven as an output (asserted) |
| show_data_oe | output | 1 | Internal transfer data driven onto the outside bus |

## Verification
The bench builds the arbiter with its default `POST_EXT_WINS`=1. This lets it check the boundary between the single core-priority decision after an outside tenure and the resumed park policy cycle by cycle. Random sequences sweep all four park codes against a mix of held and pulsed `cycle_done`, so both idle parking and mid-cycle request changes appear. Frequent high `ext_gnt_n` intervals, with `ext_access_en` toggling, reach both the no-grant state and the release path out of it.

// File: rtl/arb_pkg.sv
// Package: shared encodings for the three-master arbiter.
// Assumes: owner codes fit in two bits; park codes are fixed by the port contract.
package arb_pkg;
    localparam int PARK_W = 2;

    typedef enum logic [1:0] {
        OWN_CORE = 2'd0,
        OWN_DMA  = 2'd1,
        OWN_EXT  = 2'd2,
        OWN_NONE = 2'd3
    } owner_e;

    typedef enum logic [PARK_W-1:0] {
        PARK_RR   = 2'b00,
        PARK_CORE = 2'b01,
        PARK_DMA  = 2'b10,
        PARK_HOLD = 2'b11
    } park_e;
endpackage

// File: rtl/arb_park_policy.sv
// Module: arb_park_policy
// Picks core or DMA under the programmed park code, given the last internal holder.
// Assumes: last_int is always OWN_CORE or OWN_DMA; the result is used only when
// the outside master and the core-first rule do not decide.
module arb_park_policy
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PARK_W-1:0] park_mode,
    input  logic              core_req,
    input  logic              dma_req,
    input  owner_e            last_int,
    output owner_e            pick
);
    logic holder_is_dma;
    assign holder_is_dma = (last_int == OWN_DMA);

    // Purpose: combinational choice between the two internal masters.
    always_comb begin
        pick = last_int;
        unique case (park_e'(park_mode))
            PARK_RR: begin
                if (core_req && dma_req)
                    pick = holder_is_dma ? OWN_CORE : OWN_DMA;
                else if (core_req)
                    pick = OWN_CORE;
                else if (dma_req)
                    pick = OWN_DMA;
            end
            PARK_CORE: pick = (dma_req && !core_req) ? OWN_DMA : OWN_CORE;
            PARK_DMA:  pick = (core_req && !dma_req) ? OWN_CORE : OWN_DMA;
            default: begin
                if (holder_is_dma)
                    pick = (core_req && !dma_req) ? OWN_CORE : OWN_DMA;
                else
                    pick = (dma_req && !core_req) ? OWN_DMA : OWN_CORE;
            end
        endcase
    end

    // R8
    park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (park_mode == PARK_HOLD && dma_req && holder_is_dma) |-> (pick == OWN_DMA));

    // R10
    rr_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (park_mode == PARK_RR && core_req && dma_req) |-> (pick != last_int));
endmodule

// File: rtl/arb_owner_fsm.sv
// Module: arb_owner_fsm
// Holds the bus owner and the last internal holder. It re-decides both on
// cycle_done and gives the core priority for POST_EXT_WINS decisions after an
// outside tenure.
// Assumes: POST_EXT_WINS >= 1; policy_pick is valid every cycle.
module arb_owner_fsm
    import arb_pkg::*;
#(
    parameter int POST_EXT_WINS = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cycle_done,
    input  logic   core_req,
    input  logic   ext_req,
    input  logic   ext_gnt_n,
    input  logic   ext_access_en,
    input  owner_e policy_pick,
    output owner_e owner,
    output owner_e last_int
);
    localparam int CNT_W = (POST_EXT_WINS > 1) ? $clog2(POST_EXT_WINS + 1) : 1;

    owner_e     nxt;
    logic       off_internal;
    logic       core_first;
    logic       leaving_ext;
    logic [CNT_W-1:0] win_cnt;

    assign off_internal = (owner == OWN_EXT) || (owner == OWN_NONE);

    // Purpose: next owner with outside priority, blocking and the core-first rule.
    always_comb begin
        core_first = ext_gnt_n || off_internal || (win_cnt != '0);
        if (ext_gnt_n && ext_req)
            nxt = OWN_EXT;
        else if (ext_gnt_n && ext_access_en)
            nxt = OWN_NONE;
        else if (core_first && core_req)
            nxt = OWN_CORE;
        else
            nxt = policy_pick;
    end

    assign leaving_ext = off_internal && (nxt == OWN_CORE || nxt == OWN_DMA);

    // Purpose: register the owner and the last internal holder on bus-cycle boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner    <= OWN_CORE;
            last_int <= OWN_CORE;
        end else if (cycle_done) begin
            owner <= nxt;
            if (nxt == OWN_CORE || nxt == OWN_DMA)
                last_int <= nxt;
        end
    end

    generate
        if (POST_EXT_WINS > 1) begin : g_win_cnt
            // Purpose: count the extra core-first decisions after an outside tenure.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    win_cnt <= '0;
                else if (cycle_done) begin
                    if (leaving_ext)
                        win_cnt <= CNT_W'(POST_EXT_WINS - 1);
                    else if (win_cnt != '0)
                        win_cnt <= win_cnt - 1'b1;
                end
            end
        end else begin : g_no_cnt
            assign win_cnt = '0;
        end
    endgenerate

    // R2
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_done |=> $stable(owner));

    // R4
    ext_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && ext_gnt_n && ext_req) |=> (owner == OWN_EXT));

    // R4
    ext_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && !ext_gnt_n) |=> (owner != OWN_EXT));

    // R5
    ext_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && ext_gnt_n && ext_access_en) |=> (owner == OWN_EXT || owner == OWN_NONE));

    // R6
    core_after_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && off_internal && !ext_gnt_n && core_req) |=> (owner == OWN_CORE));
endmodule

// File: rtl/arb_xfer_vis.sv
// Module: arb_xfer_vis
// Turns the acknowledge pin into an output and enables data visibility while an
// internal register transfer runs with outside access enabled.
// Assumes: int_reg_xfer comes from address decode outside this block.
module arb_xfer_vis
    import arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  owner_e owner,
    input  logic   ext_access_en,
    input  logic   show_data_en,
    input  logic   int_reg_xfer,
    output logic   ta_oe,
    output logic   show_data_oe
);
    logic internal_owner;

    // Purpose: acknowledge direction and data visibility enables.
    always_comb begin
        internal_owner = (owner == OWN_CORE) || (owner == OWN_DMA);
        ta_oe          = ext_access_en && int_reg_xfer && internal_owner;
        show_data_oe   = ta_oe && show_data_en;
    end

    // R11
    ta_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ta_oe |-> (ext_access_en && int_reg_xfer));

    // R12
    show_needs_ta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        show_data_oe |-> (ta_oe && show_data_en));
endmodule

// File: rtl/bus_arbiter3.sv
// Module: bus_arbiter3
// Top level of the three-master arbiter: park policy, owner register and
// transfer-visibility logic, plus decoding of the owner into one-hot grants.
// Assumes: all inputs are synchronous to clk.
module bus_arbiter3
    import arb_pkg::*;
#(
    parameter int POST_EXT_WINS = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        core_req,
    input  logic        dma_req,
    input  logic        ext_req,
    input  logic        ext_gnt_n,
    input  logic [1:0]  park_mode,
    input  logic        cycle_done,
    input  logic        ext_access_en,
    input  logic        show_data_en,
    input  logic        int_reg_xfer,
    output logic        gnt_core,
    output logic        gnt_dma,
    output logic        gnt_ext,
    output logic        ta_oe,
    output logic        show_data_oe
);
    owner_e owner;
    owner_e last_int;
    owner_e policy_pick;

    arb_park_policy u_policy (
        .clk       (clk),
        .rst_n     (rst_n),
        .park_mode (park_mode),
        .core_req  (core_req),
        .dma_req   (dma_req),
        .last_int  (last_int),
        .pick      (policy_pick)
    );

    arb_owner_fsm #(.POST_EXT_WINS(POST_EXT_WINS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cycle_done    (cycle_done),
        .core_req      (core_req),
        .ext_req       (ext_req),
        .ext_gnt_n     (ext_gnt_n),
        .ext_access_en (ext_access_en),
        .policy_pick   (policy_pick),
        .owner         (owner),
        .last_int      (last_int)
    );

    arb_xfer_vis u_vis (
        .clk           (clk),
        .rst_n         (rst_n),
        .owner         (owner),
        .ext_access_en (ext_access_en),
        .show_data_en  (show_data_en),
        .int_reg_xfer  (int_reg_xfer),
        .ta_oe         (ta_oe),
        .show_data_oe  (show_data_oe)
    );

    // Purpose: decode the owner code into the grant outputs.
    always_comb begin
        gnt_core = (owner == OWN_CORE);
        gnt_dma  = (owner == OWN_DMA);
        gnt_ext  = (owner == OWN_EXT);
    end

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_core, gnt_dma, gnt_ext}));
endmodule

// File: tb/test_bus_arbiter3.sv
module test_bus_arbiter3;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, core_req, dma_req, ext_req, ext_gnt_n, cycle_done;
    logic ext_access_en, show_data_en, int_reg_xfer;
    logic [1:0] park_mode;
    logic gnt_core, gnt_dma, gnt_ext, ta_oe, show_data_oe;

    int total = 0;
    int bad = 0;
    int m_own = 0;   // 0 core, 1 dma, 2 ext, 3 none
    int m_last = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_arbiter3 i_bus_arbiter3 (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .dma_req(dma_req),
        .ext_req(ext_req), .ext_gnt_n(ext_gnt_n), .park_mode(park_mode),
        .cycle_done(cycle_done), .ext_access_en(ext_access_en),
        .show_data_en(show_data_en), .int_reg_xfer(int_reg_xfer),
        .gnt_core(gnt_core), .gnt_dma(gnt_dma), .gnt_ext(gnt_ext),
        .ta_oe(ta_oe), .show_data_oe(show_data_oe)
    );

    // Park policy from R8 to R10.
    function automatic int policy(bit [1:0] pm, bit c, bit d, int last);
        case (pm)
            2'b00: begin
                if (c && d) return (last == 0) ? 1 : 0;
                if (c) return 0;
                if (d) return 1;
                return last;
            end
            2'b01: return (d && !c) ? 1 : 0;
            2'b10: return (c && !d) ? 0 : 1;
            default: begin
                if (last == 0) return (d && !c) ? 1 : 0;
                return (c && !d) ? 0 : 1;
            end
        endcase
    endfunction

    // Next owner from R4 to R7.
    function automatic int next_owner(int own, int last);
        if (ext_gnt_n && ext_req) return 2;
        if (ext_gnt_n && ext_access_en) return 3;
        if ((ext_gnt_n || own >= 2) && core_req) return 0;
        return policy(park_mode, core_req, dma_req, last);
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: model update at the edge, output checks at the falling edge.
    task automatic tick(string gtag);
        int exp_ta;
        @(posedge clk);
        if (!rst_n) begin
            m_own = 0; m_last = 0;
        end else if (cycle_done) begin
            m_own = next_owner(m_own, m_last);
            if (m_own < 2) m_last = m_own;
        end
        @(negedge clk);
        check(gtag, {29'd0, gnt_ext, gnt_dma, gnt_core}, (m_own == 3) ? 0 : (1 << m_own));
        check("R3", $countones({gnt_ext, gnt_dma, gnt_core}) <= 1, 1);
        exp_ta = (ext_access_en && int_reg_xfer && m_own < 2) ? 1 : 0;
        check("R11", int'(ta_oe), exp_ta);
        check("R12", int'(show_data_oe), exp_ta & int'(show_data_en));
    endtask

    task automatic set_in(bit c, bit d, bit e, bit egn, bit [1:0] pm, bit cd);
        core_req = c; dma_req = d; ext_req = e; ext_gnt_n = egn;
        park_mode = pm; cycle_done = cd;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        ext_access_en = 0; show_data_en = 0; int_reg_xfer = 0;
        set_in(0, 1, 1, 1, 2'b10, 1);
        @(negedge clk);
        tick("R1"); tick("R1");
        rst_n = 1'b1;

        // R2: no boundary, so the core keeps the bus despite the DMA request.
        set_in(0, 1, 0, 0, 2'b01, 0);
        repeat (3) tick("R2");
        cycle_done = 1;
        tick("R9");                       // DMA alone under park-core
        set_in(0, 0, 0, 0, 2'b01, 1);
        tick("R9");                       // idle parks on the core

        // R8: DMA holds under park-current while the core also asks.
        set_in(0, 1, 0, 0, 2'b11, 1);
        tick("R8");
        set_in(1, 1, 0, 0, 2'b11, 1);
        repeat (3) tick("R8");
        set_in(1, 0, 0, 0, 2'b11, 1);
        tick("R8");                       // DMA drops, core takes over

        // R10: round-robin alternation and idle hold.
        set_in(1, 1, 0, 0, 2'b00, 1);
        repeat (4) tick("R10");
        set_in(0, 0, 0, 0, 2'b00, 1);
        tick("R10");

        // R4, R6, R7: outside tenure, then one core win, then park-DMA.
        set_in(1, 1, 1, 1, 2'b10, 1);
        tick("R4");
        set_in(1, 1, 0, 0, 2'b10, 1);
        tick("R6");
        tick("R7");
        set_in(1, 1, 1, 0, 2'b10, 1);
        tick("R4");                       // outside request ignored while ext_gnt_n=0

        // R5: outside access keeps internal masters off, no one granted.
        ext_access_en = 1;
        set_in(1, 1, 0, 1, 2'b01, 1);
        tick("R5");
        set_in(0, 1, 0, 0, 2'b01, 1);
        tick("R6");                       // release from no-grant, core not asking -> DMA

        // R11, R12: acknowledge direction and visibility.
        int_reg_xfer = 1; show_data_en = 1;
        set_in(1, 0, 0, 0, 2'b01, 1);
        tick("R11");
        show_data_en = 0;
        tick("R12");
        ext_access_en = 0; show_data_en = 1;
        tick("R12");

        // Random mix across all modes.
        for (int i = 0; i < 4000; i++) begin
            set_in($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                   ($urandom_range(0, 4) == 0), 2'($urandom_range(0, 3)),
                   ($urandom_range(0, 9) < 7));
            ext_access_en = $urandom_range(0, 1);
            show_data_en  = $urandom_range(0, 1);
            int_reg_xfer  = $urandom_range(0, 1);
            tick("R4");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule